// File: doc/BRIEF.md
# Register hazard scoreboard

The scoreboard is a small in-order table that holds the destination register of every instruction between issue and commit. When an instruction issues, the decode stage pushes its destination index into the table. That index may be absent. When the oldest instruction commits, the commit stage pops the head entry. Before issuing, decode asks three combinational questions in the same cycle:

- Does source operand 1 match a pending writer?
- Does source operand 2 match a pending writer?
- Does its own destination match a pending writer?

A hit on either source is a read-after-write hazard. A hit on the destination is a write-after-write hazard, so the stage can stall and keep each register to a single in-flight writer.

The same-cycle ordering is fixed. A pop takes effect before the searches of that cycle, so the retiring writer no longer stalls issue; this relies on the register file making that write visible to reads in the same cycle. A push does not take effect before the searches. The depth is a parameter: 1 suits a two-stage pipeline and 2 suits a three-stage pipeline.

Top module: `reg_scoreboard`

## Requirements
- R1: A search port reports a hit only when its operand-valid input is high, a searchable entry carries a present destination, and the two register indices are equal.
- R2: Entries leave in the order they entered. A pop always retires the oldest entry, and younger entries stay searchable.
- R3: An entry pushed in a cycle is not seen by any search in that same cycle; it becomes searchable from the next cycle.
- R4: When a pop is accepted, the head entry is excluded from all searches in that same cycle.
- R5: The destination search port applies the same match rule as the source ports, so a write-after-write conflict is reported when the issuing destination equals a pending one.
- R6: A push while the table is full and no pop is requested is dropped: the contents do not change, and `ins_err_o` is high in that cycle. A push while full together with a pop is accepted.
- R7: A pop while the table is empty is ignored and leaves it empty.
- R8: Slots that have been freed never produce a hit, whatever they last held.
- R9: `empty_o` is high exactly when no entries are held, and `full_o` is high exactly when DEPTH entries are held. After reset the table is empty.
- R10: A push with an absent destination (`ins_dst_vld_i` low) occupies a slot and keeps its place in order, but never produces a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ins_i | input | 1 | Push request for an issuing instruction |
| ins_dst_vld_i | input | 1 | Issuing instruction has a destination |
| ins_dst_i | input | IDX_W | Destination register index to push |
| rem_i | input | 1 | Pop the oldest entry (commit) |
| src1_vld_i | input | 1 | Source operand 1 present |
| src1_i | input | IDX_W | Source operand 1 index |
| src2_vld_i | input | 1 | Source operand 2 present |
| src2_i | input | IDX_W | Source operand 2 index |
| dst_vld_i | input | 1 | Destination present, for the write-after-write check |
| dst_i | input | IDX_W | Destination index, for the write-after-write check |
| hit_src1_o | output | 1 | Source 1 matches a pending writer |
| hit_src2_o | output | 1 | Source 2 matches a pending writer |
| hit_dst_o | output | 1 | Destination matches a pending writer |
| full_o | output | 1 | DEPTH entries held |
| empty_o | output | 1 | No entries held |
| ins_err_o | output | 1 | Push dropped because the table is full |

## Verification
The assertions check the following on every cycle:

- An absent operand or an empty visible set never hits.
- The head alone, while it is being popped, never hits.
- Occupancy stays within DEPTH.
- A dropped push leaves the count unchanged.
- A pop on an empty table keeps it empty.

Only the bench's scenarios can show the following:

- Same-cycle push invisibility.
- The exact order of retirement.
- Absent-destination entries taking a slot.
- Freed slots staying silent after wrap-around.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int unsigned SB_DEPTH_DEF = 2;
  localparam int unsigned SB_IDX_W_DEF = 5;
  localparam int unsigned SB_NUM_PORTS = 3; // src1, src2, dst
endpackage

// File: rtl/sb_store.sv
module sb_store #(
  parameter int unsigned DEPTH = sb_pkg::SB_DEPTH_DEF,
  parameter int unsigned IDX_W = sb_pkg::SB_IDX_W_DEF
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        ins_i,
  input  logic                        ins_dvld_i,
  input  logic [IDX_W-1:0]            ins_idx_i,
  input  logic                        rem_i,
  output logic [DEPTH-1:0][IDX_W-1:0] ent_idx_o,
  output logic [DEPTH-1:0]            ent_dvld_o,
  output logic [DEPTH-1:0]            occ_o,
  output logic [DEPTH-1:0]            head_oh_o,
  output logic                        rem_acc_o,
  output logic                        full_o,
  output logic                        empty_o,
  output logic                        ins_err_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DEPTH-1:0][IDX_W-1:0] idx_q;
  logic [DEPTH-1:0] dvld_q;
  logic ins_acc;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + PTR_W'(1);
  endfunction

  assign full_o    = (cnt_q == CNT_MAX);
  assign empty_o   = (cnt_q == '0);
  assign rem_acc_o = rem_i && !empty_o;
  // pop frees a slot first, so a push into a full table is legal alongside it
  assign ins_acc   = ins_i && (!full_o || rem_acc_o);
  assign ins_err_o = ins_i && full_o && !rem_acc_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      idx_q  <= '0;
      dvld_q <= '0;
    end else begin
      if (ins_acc) begin
        idx_q[tail_q]  <= ins_idx_i;
        dvld_q[tail_q] <= ins_dvld_i;
        tail_q         <= ptr_inc(tail_q);
      end
      if (rem_acc_o) head_q <= ptr_inc(head_q);
      if (ins_acc && !rem_acc_o)      cnt_q <= cnt_q + CNT_W'(1);
      else if (!ins_acc && rem_acc_o) cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  always_comb begin
    for (int i = 0; i < int'(DEPTH); i++) begin
      int off;
      off = (i + int'(DEPTH) - int'(head_q)) % int'(DEPTH);
      occ_o[i]     = (off < int'(cnt_q));
      head_oh_o[i] = (i == int'(head_q));
    end
  end

  assign ent_idx_o  = idx_q;
  assign ent_dvld_o = dvld_q;

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_i && full_o && !rem_i |=> full_o && (cnt_q == $past(cnt_q)));
  assert_pop_empty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_i && empty_o && !ins_i |=> empty_o);
  assert_cnt_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);
  assert_push_fills_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_i && !rem_i && !ins_err_o |=> !empty_o);
endmodule

// File: rtl/sb_search.sv
module sb_search #(
  parameter int unsigned DEPTH = sb_pkg::SB_DEPTH_DEF,
  parameter int unsigned IDX_W = sb_pkg::SB_IDX_W_DEF
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [DEPTH-1:0][IDX_W-1:0] ent_idx_i,
  input  logic [DEPTH-1:0]            ent_dvld_i,
  input  logic [DEPTH-1:0]            vis_i,
  input  logic                        op_vld_i,
  input  logic [IDX_W-1:0]            op_i,
  output logic                        hit_o
);
  logic [DEPTH-1:0] match;

  for (genvar g = 0; g < int'(DEPTH); g++) begin : g_cmp
    assign match[g] = vis_i[g] && ent_dvld_i[g] && (ent_idx_i[g] == op_i);
  end

  assign hit_o = op_vld_i && (|match);

  assert_absent_op_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_vld_i |-> !hit_o);
  assert_nothing_visible_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vis_i == '0) |-> !hit_o);
endmodule

// File: rtl/reg_scoreboard.sv
module reg_scoreboard #(
  parameter int unsigned DEPTH = sb_pkg::SB_DEPTH_DEF,
  parameter int unsigned IDX_W = sb_pkg::SB_IDX_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ins_i,
  input  logic             ins_dst_vld_i,
  input  logic [IDX_W-1:0] ins_dst_i,
  input  logic             rem_i,
  input  logic             src1_vld_i,
  input  logic [IDX_W-1:0] src1_i,
  input  logic             src2_vld_i,
  input  logic [IDX_W-1:0] src2_i,
  input  logic             dst_vld_i,
  input  logic [IDX_W-1:0] dst_i,
  output logic             hit_src1_o,
  output logic             hit_src2_o,
  output logic             hit_dst_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             ins_err_o
);
  localparam int unsigned NP = sb_pkg::SB_NUM_PORTS;

  logic [DEPTH-1:0][IDX_W-1:0] ent_idx;
  logic [DEPTH-1:0] ent_dvld, occ, head_oh, vis;
  logic rem_acc;
  logic [NP-1:0] op_vld, hit;
  logic [NP-1:0][IDX_W-1:0] op;

  sb_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ins_i      (ins_i),
    .ins_dvld_i (ins_dst_vld_i),
    .ins_idx_i  (ins_dst_i),
    .rem_i      (rem_i),
    .ent_idx_o  (ent_idx),
    .ent_dvld_o (ent_dvld),
    .occ_o      (occ),
    .head_oh_o  (head_oh),
    .rem_acc_o  (rem_acc),
    .full_o     (full_o),
    .empty_o    (empty_o),
    .ins_err_o  (ins_err_o)
  );

  // retiring head is hidden; same-cycle push is not yet in occ
  assign vis = occ & ~(rem_acc ? head_oh : '0);

  assign op_vld = {dst_vld_i, src2_vld_i, src1_vld_i};
  assign op     = {dst_i, src2_i, src1_i};

  for (genvar p = 0; p < int'(NP); p++) begin : g_port
    sb_search #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_search (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ent_idx_i  (ent_idx),
      .ent_dvld_i (ent_dvld),
      .vis_i      (vis),
      .op_vld_i   (op_vld[p]),
      .op_i       (op[p]),
      .hit_o      (hit[p])
    );
  end

  assign hit_src1_o = hit[0];
  assign hit_src2_o = hit[1];
  assign hit_dst_o  = hit[2];

  assert_pop_hides_head_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_i && ($countones(occ) == 1) |-> !hit_src1_o && !hit_src2_o && !hit_dst_o);
  assert_empty_silent_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !hit_src1_o && !hit_src2_o && !hit_dst_o);
endmodule

// File: tb/sim_reg_scoreboard.sv
module sim_reg_scoreboard;
  localparam int unsigned IW = 5;

  typedef struct packed {
    logic iv; logic idv; logic [IW-1:0] id; logic rm;
    logic s1v; logic [IW-1:0] s1; logic s2v; logic [IW-1:0] s2;
    logic dv; logic [IW-1:0] d;
    logic e1; logic e2; logic ed; logic eerr; logic efull; logic eempty;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VT [NV] = '{
    '{1,1,5'd3,0, 1,5'd3, 1,5'd3, 1,5'd3, 0,0,0,0,0,1}, // R3 push hidden
    '{0,0,5'd0,0, 1,5'd3, 0,5'd3, 1,5'd4, 1,0,0,0,0,0}, // R1
    '{1,0,5'd0,0, 1,5'd0, 1,5'd3, 1,5'd3, 0,1,1,0,0,0}, // R5 R10
    '{0,0,5'd0,0, 1,5'd0, 1,5'd3, 0,5'd3, 0,1,0,0,1,0}, // R10 R9
    '{1,1,5'd7,0, 1,5'd7, 0,5'd0, 0,5'd0, 0,0,0,1,1,0}, // R6 drop
    '{1,1,5'd9,1, 1,5'd3, 1,5'd9, 1,5'd0, 0,0,0,0,1,0}, // R4 R6 push+pop
    '{0,0,5'd0,0, 1,5'd9, 1,5'd3, 1,5'd9, 1,0,1,0,1,0}, // R2 R8
    '{0,0,5'd0,1, 1,5'd9, 1,5'd3, 0,5'd0, 1,0,0,0,1,0}, // R2
    '{0,0,5'd0,1, 1,5'd9, 0,5'd0, 0,5'd0, 0,0,0,0,0,0}, // R4
    '{0,0,5'd0,1, 1,5'd9, 1,5'd3, 1,5'd0, 0,0,0,0,0,1}, // R7
    '{0,0,5'd0,0, 1,5'd9, 1,5'd3, 1,5'd0, 0,0,0,0,0,1}  // R7 R8
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ins, ins_dv, rem, s1v, s2v, dv;
  logic [IW-1:0] ins_d, s1, s2, d;
  logic h1, h2, hd, full, empty, err;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  reg_scoreboard #(.DEPTH(2), .IDX_W(IW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ins_i(ins), .ins_dst_vld_i(ins_dv), .ins_dst_i(ins_d),
    .rem_i(rem), .src1_vld_i(s1v), .src1_i(s1), .src2_vld_i(s2v), .src2_i(s2),
    .dst_vld_i(dv), .dst_i(d), .hit_src1_o(h1), .hit_src2_o(h2), .hit_dst_o(hd),
    .full_o(full), .empty_o(empty), .ins_err_o(err)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input vec_t v);
    ins = v.iv; ins_dv = v.idv; ins_d = v.id; rem = v.rm;
    s1v = v.s1v; s1 = v.s1; s2v = v.s2v; s2 = v.s2; dv = v.dv; d = v.d;
  endtask

  task automatic idle();
    drive('0);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    idle();
    #25;
    // R9 reset state
    chk("R9 empty after reset", empty, 1'b1);
    chk("R9 full after reset", full, 1'b0);
    chk("R6 err after reset", err, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VT[i]);
      #5;
      chk($sformatf("R1/R3/R4 v%0d hit1", i), h1, VT[i].e1);
      chk($sformatf("R1/R2 v%0d hit2", i), h2, VT[i].e2);
      chk($sformatf("R5 v%0d hitd", i), hd, VT[i].ed);
      chk($sformatf("R6 v%0d err", i), err, VT[i].eerr);
      chk($sformatf("R9 v%0d full", i), full, VT[i].efull);
      chk($sformatf("R9 v%0d empty", i), empty, VT[i].eempty);
    end

    // R2 ordering with max index: push r31 then r1
    @(negedge clk); idle(); ins = 1; ins_dv = 1; ins_d = 5'd31;
    @(negedge clk); ins_d = 5'd1;
    @(negedge clk); idle(); rem = 1; s1v = 1; s1 = 5'd1; s2v = 1; s2 = 5'd31;
    #5;
    chk("R2 younger still visible", h1, 1'b1);
    chk("R4 retiring oldest hidden", h2, 1'b0);
    @(negedge clk); idle(); s2v = 1; s2 = 5'd31; dv = 1; d = 5'd1;
    #5;
    chk("R8 freed slot silent", h2, 1'b0);
    chk("R5 dst conflict", hd, 1'b1);

    // R9 reset clears a non-empty table
    @(negedge clk); rst_n = 1'b0;
    #5;
    chk("R9 empty after mid reset", empty, 1'b1);
    chk("R8 no hit after reset", hd, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    // R6 depth-one style: full then push with pop, new entry visible next cycle
    @(negedge clk); idle(); ins = 1; ins_dv = 1; ins_d = 5'd12;
    @(negedge clk); ins_d = 5'd13;
    @(negedge clk); ins_d = 5'd14; rem = 1;
    #5;
    chk("R6 push with pop accepted", err, 1'b0);
    @(negedge clk); idle(); s1v = 1; s1 = 5'd14;
    #5;
    chk("R6 pushed entry visible", h1, 1'b1);
    chk("R9 still full", full, 1'b1);

    done = 1;
    finish_run();
  end
endmodule